// File: doc/BRIEF.md
# Byte-Table Binary to Packed BCD Converter

This block turns an unsigned binary word into its packed decimal form. It does not double the value one bit at a time. It splits the operand into bytes and looks up each byte in a constant table. For the byte at position k, the table returns the decimal value of that byte times 256^k, already in BCD. A decimal adder sums these partial values into an accumulator that is as wide as the full result. The lowest byte is processed first, and one byte is added per clock. A 32-bit operand therefore needs four addition cycles.

A client drives `start` for one cycle with the operand. `busy` stays high while the additions run. `done` pulses once when the result is ready. The result then holds until the next accepted start. The tables are computed during elaboration, so the whole block is synthesizable with no initialisation file.

Top module: `bcd_lut_converter`

## Requirements
- R1: While reset is active and right after it is released, `busy` and `done` are 0 and `result` is all zeros.
- R2: A `start` seen while `busy` is low captures `operand`. In the next cycle `busy` is 1 and `result` reads 0, because the accumulator has been cleared.
- R3: Suppose a start is accepted on clock edge n. Then `done` is 1 for exactly the one cycle that follows edge n+4, and `busy` drops in that same cycle.
- R4: When `done` is 1, `result` is the exact decimal value of the captured operand in packed BCD. Decimal digit i sits in bits [4i+3:4i], so the units digit is in bits [3:0].
- R5: Every 4-bit digit of `result` holds 0 to 9 in every cycle.
- R6: A `start` that arrives while `busy` is 1 is ignored. The running conversion completes with the operand captured originally and finishes at the original time.
- R7: After `done`, `result` stays unchanged until the next accepted start.
- R8: Boundary operands convert exactly and never produce a carry out of the top digit. These operands are 0, 0xFFFFFFFF (4294967295), 0xAABBCCDD (2864434397), 0xFFFFFFAA (4294967210), and every single-byte value placed in each byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion of `operand` (accepted only when idle) |
| operand | input | 32 | Unsigned binary value to convert |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 40 | Packed BCD, ten digits, least significant digit in bits [3:0] |

## Verification
The assertions check properties that must hold on every cycle. Each accumulator digit stays a legal decimal digit. The decimal adder never carries out of its top digit during a conversion. `done` lasts exactly one cycle and never occurs together with `busy`. A start during `busy` leaves the captured operand unchanged, and the result is stable while idle. Numerical correctness needs the bench's scenarios. These cover the exact decimal value, including the carries that ripple across digit positions. They also cover the fixed four-cycle latency and the fact that an ignored start does not change the outcome. The bench walks every byte value through every byte position, plus corner and pseudo-random operands, and compares each result with a decimal expansion computed by repeated division.

// File: rtl/bcd_lut_pkg.sv
package bcd_lut_pkg;

  localparam int DIGIT_W = 4;

  // Decimal expansion of a value into up to 16 packed digits (elaboration use).
  function automatic logic [63:0] to_bcd64(input longint unsigned value);
    logic [63:0] packed_digits;
    longint unsigned rest;
    packed_digits = '0;
    rest = value;
    for (int i = 0; i < 16; i++) begin
      packed_digits[i*DIGIT_W +: DIGIT_W] = DIGIT_W'(rest % 10);
      rest = rest / 10;
    end
    return packed_digits;
  endfunction

  // One decimal digit position: returns {carry_out, digit_sum}.
  function automatic logic [DIGIT_W:0] bcd_digit_add(input logic [DIGIT_W-1:0] a,
                                                     input logic [DIGIT_W-1:0] b,
                                                     input logic cin);
    logic [DIGIT_W:0] raw;
    logic [DIGIT_W:0] fixed;
    raw = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
    if (raw > 5'd9) begin
      fixed = raw + 5'd6;
      return {1'b1, fixed[DIGIT_W-1:0]};
    end
    return {1'b0, raw[DIGIT_W-1:0]};
  endfunction

endpackage

// File: rtl/byte_weight_rom.sv
module byte_weight_rom
  import bcd_lut_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIGITS = 10,
  parameter int POS    = 0
) (
  input  logic [BYTE_W-1:0]         addr,
  output logic [DIGITS*DIGIT_W-1:0] weight
);
  localparam int ENTRIES = 1 << BYTE_W;
  localparam int RES_W   = DIGITS * DIGIT_W;
  localparam longint unsigned SCALE = longint'(1) << (BYTE_W * POS);

  logic [RES_W-1:0] table_q [ENTRIES];

  // Each entry: BCD of (entry index * 256^POS), fixed at elaboration.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam logic [63:0] FULL = to_bcd64(longint'(e) * SCALE);
    assign table_q[e] = FULL[RES_W-1:0];
  end

  assign weight = table_q[addr];

endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder
  import bcd_lut_pkg::*;
#(
  parameter int DIGITS = 10
) (
  input  logic [DIGITS*DIGIT_W-1:0] a,
  input  logic [DIGITS*DIGIT_W-1:0] b,
  output logic [DIGITS*DIGIT_W-1:0] sum,
  output logic                      carry_out
);
  logic carry [DIGITS+1];

  assign carry[0] = 1'b0;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [DIGIT_W:0] slice;
    assign slice = bcd_digit_add(a[d*DIGIT_W +: DIGIT_W], b[d*DIGIT_W +: DIGIT_W], carry[d]);
    assign sum[d*DIGIT_W +: DIGIT_W] = slice[DIGIT_W-1:0];
    assign carry[d+1] = slice[DIGIT_W];
  end

  assign carry_out = carry[DIGITS];

endmodule

// File: rtl/bcd_lut_converter.sv
module bcd_lut_converter
  import bcd_lut_pkg::*;
#(
  parameter int IN_W   = 32,
  parameter int BYTE_W = 8,
  parameter int DIGITS = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [IN_W-1:0]           operand,
  output logic                      busy,
  output logic                      done,
  output logic [DIGITS*DIGIT_W-1:0] result
);
  localparam int NUM_BYTES = IN_W / BYTE_W;
  localparam int STEP_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int RES_W     = DIGITS * DIGIT_W;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_BYTES - 1);

  logic [IN_W-1:0]   operand_q;
  logic [STEP_W-1:0] step_q;
  logic [RES_W-1:0]  acc_q;
  logic              busy_q;
  logic              done_q;

  // Named internal events
  logic              accept;
  logic              last_add;
  logic [RES_W-1:0]  cur_weight;
  logic [RES_W-1:0]  acc_next;
  logic              top_carry;
  logic [RES_W-1:0]  rom_out [NUM_BYTES];

  assign accept   = start && !busy_q;
  assign last_add = busy_q && (step_q == LAST_STEP);

  // One weight table per byte position
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_rom
    byte_weight_rom #(
      .BYTE_W (BYTE_W),
      .DIGITS (DIGITS),
      .POS    (k)
    ) u_rom (
      .addr   (operand_q[k*BYTE_W +: BYTE_W]),
      .weight (rom_out[k])
    );
  end

  assign cur_weight = rom_out[step_q];

  bcd_ripple_adder #(
    .DIGITS (DIGITS)
  ) u_adder (
    .a         (acc_q),
    .b         (cur_weight),
    .sum       (acc_next),
    .carry_out (top_carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand_q <= '0;
      step_q    <= '0;
      acc_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        operand_q <= operand;
        acc_q     <= '0;
        step_q    <= '0;
        busy_q    <= 1'b1;
      end else if (busy_q) begin
        acc_q  <= acc_next;
        step_q <= step_q + STEP_W'(1);
        if (last_add) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = acc_q;

  // ---------------- assertions ----------------
  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && result == '0));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_last_add_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_add |=> done);

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit_chk
    assert_digit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q[d*DIGIT_W +: DIGIT_W] <= 4'd9);
  end

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(operand_q));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(result));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !top_carry);

endmodule

// File: tb/bcd_lut_converter_bench.sv
module bcd_lut_converter_bench;
  localparam int IN_W  = 32;
  localparam int RES_W = 40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [IN_W-1:0]  operand = '0;
  logic             busy;
  logic             done;
  logic [RES_W-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;  // 250 MHz

  bcd_lut_converter u_bcd_lut_converter (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .busy    (busy),
    .done    (done),
    .result  (result)
  );

  // Decimal expansion by repeated division, packed units-first
  function automatic logic [RES_W-1:0] expect_bcd(input logic [IN_W-1:0] v);
    logic [RES_W-1:0] r;
    longint unsigned t;
    r = '0;
    t = longint'(v);
    for (int i = 0; i < RES_W/4; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One conversion; optionally injects a start while busy (R6)
  task automatic run_conv(input logic [IN_W-1:0] v, input bit inject);
    logic [RES_W-1:0] want;
    want = expect_bcd(v);
    @(negedge clk);
    start = 1'b1; operand = v;
    @(negedge clk);                       // after accepting edge n
    start = 1'b0; operand = ~v;
    chk(busy === 1'b1 && done === 1'b0, "R2 busy after start", {62'd0, busy, done}, 64'h2);
    chk(result === '0, "R2 accumulator cleared", 64'(result), 64'd0);
    if (inject) begin
      start = 1'b1; operand = 32'h1357_9BDF;
    end
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b0 && busy === 1'b1, "R3 no early done", {62'd0, busy, done}, 64'h2);
    end
    @(negedge clk);                       // after edge n+4
    chk(done === 1'b1 && busy === 1'b0, "R3 done at n+4", {62'd0, busy, done}, 64'h1);
    chk(result === want, inject ? "R6 result of original operand" : "R4 decimal value",
        64'(result), 64'(want));
    @(negedge clk);
    operand = v ^ 32'hA5A5_5A5A;
    chk(done === 1'b0, "R3 done single cycle", {63'd0, done}, 64'd0);
    chk(result === want, "R7 result held", 64'(result), 64'(want));
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", n_checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result === '0, "R1 state in reset",
        {21'd0, busy, done, result}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result === '0, "R1 state after reset",
        {21'd0, busy, done, result}, 64'd0);

    // R8 corners
    run_conv(32'h0000_0000, 1'b0);
    run_conv(32'hFFFF_FFFF, 1'b0);
    run_conv(32'hAABB_CCDD, 1'b0);
    run_conv(32'hFFFF_FFAA, 1'b0);
    chk(expect_bcd(32'hAABB_CCDD) == 40'h28_6443_4397, "R8 reference expansion",
        64'(expect_bcd(32'hAABB_CCDD)), 64'h28_6443_4397);

    // R8 every byte value in every byte position
    for (int pos = 0; pos < 4; pos++)
      for (int b = 0; b < 256; b++)
        run_conv(32'(b) << (8 * pos), 1'b0);

    // R6 start during busy ignored
    run_conv(32'h0000_0001, 1'b1);
    run_conv(32'hFFFF_FFAA, 1'b1);
    run_conv(32'h0098_9680, 1'b1);

    // R4 pseudo-random operands
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_conv(lfsr, (i % 16) == 0);
    end

    // R7 long idle hold
    run_conv(32'd999_999_999, 1'b0);
    repeat (5) @(negedge clk);
    chk(result === expect_bcd(32'd999_999_999), "R7 result held while idle",
        64'(result), 64'(expect_bcd(32'd999_999_999)));

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule